// File: doc/BRIEF.md
# Signature-Tagged Operand Delivery Stage

This block is the operand-delivery stage in front of one execution port. Each register value in the core carries a small dataflow signature next to its data word. The block keeps a physical register array in which every entry holds a data word and its signature. It also watches a set of result buses. Each result bus carries a valid bit, a destination physical tag, a data word and that result's signature.

A result bus does two jobs in the same cycle. It writes its data and signature into the addressed register entry, and it bypasses them to any operand read of the same tag. For each of the two source operands, one selection decision picks either the register-array read or a matching result bus. The chosen data word and its signature are always moved together. The three signatures that come with the issued instruction are carried through unchanged: the expected signature of each source and the destination signature. A downstream checker compares them with the delivered ones.

Issued instructions arrive on a valid/ready interface, and prepared operands leave on another. There is one register stage between the two. An instruction is accepted on a clock edge where `iss_valid` and `iss_ready` are both high, and its operands appear on the output from the next cycle. While `op_valid` is high and `op_ready` is low, the output holds its contents and `iss_ready` stays low, so nothing is lost. The result buses are plain broadcasts and cannot be stalled.

Top module: `sigop_operand_stage`

## Requirements
- R1: After reset, every register entry reads data 0 and signature 0, `op_valid` is 0 and `iss_ready` is 1.
- R2: When no valid result bus carries a source's tag, that source gets the data and signature held in the register entry.
- R3: When a valid result bus carries a source's tag in the accept cycle, that source gets that bus's data and signature instead of the register entry.
- R4: When several valid buses carry the same source tag, the bus with the lowest index wins, because bus 0 is the youngest result.
- R5: A valid result bus writes its data and signature into the entry named by its tag, and later reads of that entry return them.
- R6: When two valid buses write the same entry in the same cycle, the entry keeps the values from the lower-index bus.
- R7: A read of an entry in the cycle it is written returns the newly written data and signature (write-through).
- R8: The two sources are selected independently. One may come from a bus and the other from the register array, or from a different bus.
- R9: `op_exp1_sig`, `op_exp2_sig` and `op_dst_sig` equal the `iss_exp1_sig`, `iss_exp2_sig` and `iss_dst_sig` values of the instruction that was accepted.
- R10: While `op_valid` is 1 and `op_ready` is 0, every output field holds its value and `iss_ready` is 0. Otherwise `iss_ready` is 1.
- R11: A result bus whose valid bit is 0 neither bypasses nor writes, even when its tag matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issued instruction present |
| iss_ready | output | 1 | Stage can accept an instruction |
| iss_src1_tag | input | TAG_W | Physical tag of source 1 |
| iss_src2_tag | input | TAG_W | Physical tag of source 2 |
| iss_exp1_sig | input | SIG_W | Expected signature of source 1 |
| iss_exp2_sig | input | SIG_W | Expected signature of source 2 |
| iss_dst_sig | input | SIG_W | Destination signature |
| res_valid | input | NUM_BUS | Per-bus result valid, bit b for bus b |
| res_tag | input | NUM_BUS*TAG_W | Per-bus destination tag, bus b at bits [b*TAG_W +: TAG_W] |
| res_data | input | NUM_BUS*DATA_W | Per-bus data, bus b at bits [b*DATA_W +: DATA_W] |
| res_sig | input | NUM_BUS*SIG_W | Per-bus signature, bus b at bits [b*SIG_W +: SIG_W] |
| op_valid | output | 1 | Prepared operands present |
| op_ready | input | 1 | Functional unit takes the operands |
| op_src1_data | output | DATA_W | Delivered source 1 data |
| op_src1_sig | output | SIG_W | Signature that came with source 1 |
| op_src2_data | output | DATA_W | Delivered source 2 data |
| op_src2_sig | output | SIG_W | Signature that came with source 2 |
| op_exp1_sig | output | SIG_W | Expected source 1 signature, passed through |
| op_exp2_sig | output | SIG_W | Expected source 2 signature, passed through |
| op_dst_sig | output | SIG_W | Destination signature, passed through |

## Verification
The selection is tried with five input patterns:
- Reads with no bus traffic at all. These separate a reset-cleared array from stale contents.
- Reads with buses busy on unrelated tags. These show that a tag compare, and not mere bus activity, triggers a bypass.
- Reads where each source matches a different bus. These show that the data word and the signature are selected by the same control.
- Reads where both buses match one source. These expose an inverted priority, both in the bypass and in the array write.
- Reads where a bus carries a matching tag but has its valid bit low. These show that the valid bit gates both the bypass and the write.

A stall pattern holds `op_ready` low while an instruction waits. It checks that the output stays frozen and that no instruction is accepted during the stall.

// File: rtl/sigop_pkg.sv
package sigop_pkg;
  // Default sizing shared by the operand stage and its checker.
  localparam int DEF_DATA_W   = 32;
  localparam int DEF_NUM_REGS = 32;
  localparam int DEF_NUM_BUS  = 2;
  localparam int DEF_SIG_W    = 3;
  // Number of source operands delivered per instruction.
  localparam int NUM_SRC      = 2;
endpackage

// File: rtl/sigop_regfile.sv
module sigop_regfile #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  parameter int SIG_W    = 3,
  parameter int NUM_BUS  = 2,
  parameter int TAG_W    = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BUS-1:0]          wr_valid,
  input  logic [NUM_BUS*TAG_W-1:0]    wr_tag,
  input  logic [NUM_BUS*DATA_W-1:0]   wr_data,
  input  logic [NUM_BUS*SIG_W-1:0]    wr_sig,
  input  logic [TAG_W-1:0]            rd_tag_a,
  input  logic [TAG_W-1:0]            rd_tag_b,
  output logic [DATA_W-1:0]           rd_data_a,
  output logic [SIG_W-1:0]            rd_sig_a,
  output logic [DATA_W-1:0]           rd_data_b,
  output logic [SIG_W-1:0]            rd_sig_b
);
  logic [DATA_W-1:0] ent_data [NUM_REGS];
  logic [SIG_W-1:0]  ent_sig  [NUM_REGS];

  // Buses are visited from oldest to youngest, so the youngest write is the
  // last nonblocking assignment to an entry and wins a same-tag collision.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        ent_data[r] <= '0;
        ent_sig[r]  <= '0;
      end
    end else begin
      for (int b = NUM_BUS - 1; b >= 0; b--) begin
        if (wr_valid[b]) begin
          ent_data[wr_tag[b*TAG_W +: TAG_W]] <= wr_data[b*DATA_W +: DATA_W];
          ent_sig[wr_tag[b*TAG_W +: TAG_W]]  <= wr_sig[b*SIG_W +: SIG_W];
        end
      end
    end
  end

  // Combinational reads. A write in the same cycle reaches the reader
  // through the bypass selector, not through the array.
  assign rd_data_a = ent_data[rd_tag_a];
  assign rd_sig_a  = ent_sig[rd_tag_a];
  assign rd_data_b = ent_data[rd_tag_b];
  assign rd_sig_b  = ent_sig[rd_tag_b];
endmodule

// File: rtl/sigop_operand_sel.sv
module sigop_operand_sel #(
  parameter int DATA_W  = 32,
  parameter int SIG_W   = 3,
  parameter int NUM_BUS = 2,
  parameter int TAG_W   = 5
) (
  input  logic [TAG_W-1:0]            src_tag,
  input  logic [DATA_W-1:0]           rf_data,
  input  logic [SIG_W-1:0]            rf_sig,
  input  logic [NUM_BUS-1:0]          bus_valid,
  input  logic [NUM_BUS*TAG_W-1:0]    bus_tag,
  input  logic [NUM_BUS*DATA_W-1:0]   bus_data,
  input  logic [NUM_BUS*SIG_W-1:0]    bus_sig,
  output logic [DATA_W-1:0]           op_data,
  output logic [SIG_W-1:0]            op_sig
);
  logic [NUM_BUS-1:0] hit;

  // One tag comparator per bus.
  for (genvar g = 0; g < NUM_BUS; g++) begin : g_cmp
    assign hit[g] = bus_valid[g] && (bus_tag[g*TAG_W +: TAG_W] == src_tag);
  end

  // One select steers the data word and its signature together. The loop
  // runs from the oldest bus down to bus 0, so bus 0 is the last to
  // override and has the highest priority.
  always_comb begin
    op_data = rf_data;
    op_sig  = rf_sig;
    for (int b = NUM_BUS - 1; b >= 0; b--) begin
      if (hit[b]) begin
        op_data = bus_data[b*DATA_W +: DATA_W];
        op_sig  = bus_sig[b*SIG_W +: SIG_W];
      end
    end
  end
endmodule

// File: rtl/sigop_out_stage.sv
module sigop_out_stage #(
  parameter int PAY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PAY_W-1:0] in_payload,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PAY_W-1:0] out_payload
);
  logic             full_q;
  logic [PAY_W-1:0] pay_q;

  // The stage takes a new item when it is empty or is being drained.
  assign in_ready = !full_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      pay_q  <= '0;
    end else if (in_ready) begin
      full_q <= in_valid;
      if (in_valid) pay_q <= in_payload;
    end
  end

  assign out_valid   = full_q;
  assign out_payload = pay_q;
endmodule

// File: rtl/sigop_operand_stage.sv
module sigop_operand_stage
  import sigop_pkg::*;
#(
  parameter int DATA_W   = DEF_DATA_W,
  parameter int NUM_REGS = DEF_NUM_REGS,
  parameter int NUM_BUS  = DEF_NUM_BUS,
  parameter int SIG_W    = DEF_SIG_W,
  localparam int TAG_W   = $clog2(NUM_REGS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        iss_valid,
  output logic                        iss_ready,
  input  logic [TAG_W-1:0]            iss_src1_tag,
  input  logic [TAG_W-1:0]            iss_src2_tag,
  input  logic [SIG_W-1:0]            iss_exp1_sig,
  input  logic [SIG_W-1:0]            iss_exp2_sig,
  input  logic [SIG_W-1:0]            iss_dst_sig,
  input  logic [NUM_BUS-1:0]          res_valid,
  input  logic [NUM_BUS*TAG_W-1:0]    res_tag,
  input  logic [NUM_BUS*DATA_W-1:0]   res_data,
  input  logic [NUM_BUS*SIG_W-1:0]    res_sig,
  output logic                        op_valid,
  input  logic                        op_ready,
  output logic [DATA_W-1:0]           op_src1_data,
  output logic [SIG_W-1:0]            op_src1_sig,
  output logic [DATA_W-1:0]           op_src2_data,
  output logic [SIG_W-1:0]            op_src2_sig,
  output logic [SIG_W-1:0]            op_exp1_sig,
  output logic [SIG_W-1:0]            op_exp2_sig,
  output logic [SIG_W-1:0]            op_dst_sig
);
  localparam int OPND_W = DATA_W + SIG_W;
  localparam int PAY_W  = NUM_SRC * OPND_W + 3 * SIG_W;

  logic [TAG_W-1:0]  src_tag  [NUM_SRC];
  logic [DATA_W-1:0] rf_data  [NUM_SRC];
  logic [SIG_W-1:0]  rf_sig   [NUM_SRC];
  logic [DATA_W-1:0] sel_data [NUM_SRC];
  logic [SIG_W-1:0]  sel_sig  [NUM_SRC];

  assign src_tag[0] = iss_src1_tag;
  assign src_tag[1] = iss_src2_tag;

  sigop_regfile #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SIG_W(SIG_W),
    .NUM_BUS(NUM_BUS), .TAG_W(TAG_W)
  ) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (res_valid),
    .wr_tag    (res_tag),
    .wr_data   (res_data),
    .wr_sig    (res_sig),
    .rd_tag_a  (src_tag[0]),
    .rd_tag_b  (src_tag[1]),
    .rd_data_a (rf_data[0]),
    .rd_sig_a  (rf_sig[0]),
    .rd_data_b (rf_data[1]),
    .rd_sig_b  (rf_sig[1])
  );

  // One selector per source operand.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    sigop_operand_sel #(
      .DATA_W(DATA_W), .SIG_W(SIG_W), .NUM_BUS(NUM_BUS), .TAG_W(TAG_W)
    ) u_sel (
      .src_tag   (src_tag[s]),
      .rf_data   (rf_data[s]),
      .rf_sig    (rf_sig[s]),
      .bus_valid (res_valid),
      .bus_tag   (res_tag),
      .bus_data  (res_data),
      .bus_sig   (res_sig),
      .op_data   (sel_data[s]),
      .op_sig    (sel_sig[s])
    );
  end

  logic [PAY_W-1:0] pay_in, pay_out;

  assign pay_in = {sel_data[0], sel_sig[0], sel_data[1], sel_sig[1],
                   iss_exp1_sig, iss_exp2_sig, iss_dst_sig};

  sigop_out_stage #(.PAY_W(PAY_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (iss_valid),
    .in_ready    (iss_ready),
    .in_payload  (pay_in),
    .out_valid   (op_valid),
    .out_ready   (op_ready),
    .out_payload (pay_out)
  );

  assign {op_src1_data, op_src1_sig, op_src2_data, op_src2_sig,
          op_exp1_sig, op_exp2_sig, op_dst_sig} = pay_out;
endmodule

// File: rtl/sigop_operand_stage_chk.sv
module sigop_operand_stage_chk #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  parameter int SIG_W    = 3,
  localparam int TAG_W   = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic [TAG_W-1:0]  iss_src1_tag,
  input logic [TAG_W-1:0]  iss_src2_tag,
  input logic [SIG_W-1:0]  iss_exp1_sig,
  input logic [SIG_W-1:0]  iss_exp2_sig,
  input logic [SIG_W-1:0]  iss_dst_sig,
  input logic              bus0_valid,
  input logic [TAG_W-1:0]  bus0_tag,
  input logic [DATA_W-1:0] bus0_data,
  input logic [SIG_W-1:0]  bus0_sig,
  input logic              op_valid,
  input logic              op_ready,
  input logic [DATA_W-1:0] op_src1_data,
  input logic [SIG_W-1:0]  op_src1_sig,
  input logic [DATA_W-1:0] op_src2_data,
  input logic [SIG_W-1:0]  op_src2_sig,
  input logic [SIG_W-1:0]  op_exp1_sig,
  input logic [SIG_W-1:0]  op_exp2_sig,
  input logic [SIG_W-1:0]  op_dst_sig
);
  // R10: a stalled output keeps every field.
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |=> (op_valid && $stable(op_src1_data) &&
      $stable(op_src1_sig) && $stable(op_src2_data) && $stable(op_src2_sig) &&
      $stable(op_exp1_sig) && $stable(op_exp2_sig) && $stable(op_dst_sig)));

  // R10: no acceptance while the output is blocked.
  a_r10_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |-> !iss_ready);

  // R9: the instruction's signatures arrive unchanged one cycle after acceptance.
  a_r9_sig_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=> (op_valid &&
      op_exp1_sig == $past(iss_exp1_sig) && op_exp2_sig == $past(iss_exp2_sig) &&
      op_dst_sig == $past(iss_dst_sig)));

  // R3 and R4: the youngest bus overrides source 1, data and signature together.
  a_r3_bus0_src1: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && bus0_valid && bus0_tag == iss_src1_tag) |=>
      (op_src1_data == $past(bus0_data) && op_src1_sig == $past(bus0_sig)));

  // R4: the youngest bus overrides source 2.
  a_r4_bus0_src2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && bus0_valid && bus0_tag == iss_src2_tag) |=>
      (op_src2_data == $past(bus0_data) && op_src2_sig == $past(bus0_sig)));
endmodule

bind sigop_operand_stage sigop_operand_stage_chk #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SIG_W(SIG_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .iss_valid    (iss_valid),
  .iss_ready    (iss_ready),
  .iss_src1_tag (iss_src1_tag),
  .iss_src2_tag (iss_src2_tag),
  .iss_exp1_sig (iss_exp1_sig),
  .iss_exp2_sig (iss_exp2_sig),
  .iss_dst_sig  (iss_dst_sig),
  .bus0_valid   (res_valid[0]),
  .bus0_tag     (res_tag[TAG_W-1:0]),
  .bus0_data    (res_data[DATA_W-1:0]),
  .bus0_sig     (res_sig[SIG_W-1:0]),
  .op_valid     (op_valid),
  .op_ready     (op_ready),
  .op_src1_data (op_src1_data),
  .op_src1_sig  (op_src1_sig),
  .op_src2_data (op_src2_data),
  .op_src2_sig  (op_src2_sig),
  .op_exp1_sig  (op_exp1_sig),
  .op_exp2_sig  (op_exp2_sig),
  .op_dst_sig   (op_dst_sig)
);

// File: tb/sigop_operand_stage_tb.sv
`timescale 1ns/1ps
module sigop_operand_stage_tb;
  localparam int DW = 32;
  localparam int NR = 32;
  localparam int NB = 2;
  localparam int SW = 3;
  localparam int TW = 5;

  typedef struct packed {
    logic [DW-1:0] d1; logic [SW-1:0] s1;
    logic [DW-1:0] d2; logic [SW-1:0] s2;
    logic [SW-1:0] e1; logic [SW-1:0] e2; logic [SW-1:0] ds;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 1'b0;
  logic iss_ready;
  logic [TW-1:0] iss_src1_tag = '0, iss_src2_tag = '0;
  logic [SW-1:0] iss_exp1_sig = '0, iss_exp2_sig = '0, iss_dst_sig = '0;
  logic [NB-1:0] res_valid = '0;
  logic [NB*TW-1:0] res_tag = '0;
  logic [NB*DW-1:0] res_data = '0;
  logic [NB*SW-1:0] res_sig = '0;
  logic op_valid;
  logic op_ready = 1'b1;
  logic [DW-1:0] op_src1_data, op_src2_data;
  logic [SW-1:0] op_src1_sig, op_src2_sig, op_exp1_sig, op_exp2_sig, op_dst_sig;

  always #2.5 clk = ~clk;

  sigop_operand_stage u_dut (.*);

  // Staged stimulus, applied at the next falling edge by tick().
  logic          st_iv = 1'b0;
  logic [TW-1:0] st_t1 = '0, st_t2 = '0;
  logic [SW-1:0] st_e1 = '0, st_e2 = '0, st_ds = '0;
  logic [NB-1:0] st_rv = '0;
  logic [NB*TW-1:0] st_rt = '0;
  logic [NB*DW-1:0] st_rd = '0;
  logic [NB*SW-1:0] st_rs = '0;
  logic          st_ordy = 1'b1;

  logic [DW-1:0] mdl_d [NR];
  logic [SW-1:0] mdl_s [NR];
  item_t sb[$];
  string sb_req[$];
  int checks = 0;
  int fails = 0;
  bit accepted;
  bit done = 1'b0;

  task automatic set_issue(input int t1, input int t2, input int e1, input int e2, input int ds);
    st_iv = 1'b1; st_t1 = TW'(t1); st_t2 = TW'(t2);
    st_e1 = SW'(e1); st_e2 = SW'(e2); st_ds = SW'(ds);
  endtask

  task automatic set_bus(input int b, input bit v, input int tag, input logic [DW-1:0] d, input int s);
    st_rv[b] = v;
    st_rt[b*TW +: TW] = TW'(tag);
    st_rd[b*DW +: DW] = d;
    st_rs[b*SW +: SW] = SW'(s);
  endtask

  // Expected operand: bus 0 first, then bus 1, then the model array.
  function automatic logic [DW+SW-1:0] pick(input logic [TW-1:0] t);
    for (int b = 0; b < NB; b++)
      if (res_valid[b] && res_tag[b*TW +: TW] == t)
        return {res_data[b*DW +: DW], res_sig[b*SW +: SW]};
    return {mdl_d[t], mdl_s[t]};
  endfunction

  task automatic tick(input string req);
    item_t it;
    @(negedge clk);
    iss_valid = st_iv; iss_src1_tag = st_t1; iss_src2_tag = st_t2;
    iss_exp1_sig = st_e1; iss_exp2_sig = st_e2; iss_dst_sig = st_ds;
    res_valid = st_rv; res_tag = st_rt; res_data = st_rd; res_sig = st_rs;
    op_ready = st_ordy;
    #0.5;
    accepted = iss_valid && iss_ready;
    if (accepted) begin
      {it.d1, it.s1} = pick(iss_src1_tag);
      {it.d2, it.s2} = pick(iss_src2_tag);
      it.e1 = iss_exp1_sig; it.e2 = iss_exp2_sig; it.ds = iss_dst_sig;
      sb.push_back(it);
      sb_req.push_back(req);
    end
    for (int b = NB - 1; b >= 0; b--)
      if (res_valid[b]) begin
        mdl_d[res_tag[b*TW +: TW]] = res_data[b*DW +: DW];
        mdl_s[res_tag[b*TW +: TW]] = res_sig[b*SW +: SW];
      end
    st_iv = 1'b0; st_rv = '0;
  endtask

  // Monitor: compares delivered operands with the scoreboard queue.
  item_t held;
  bit was_stalled = 1'b0;
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        item_t got;
        got = {op_src1_data, op_src1_sig, op_src2_data, op_src2_sig,
               op_exp1_sig, op_exp2_sig, op_dst_sig};
        if (was_stalled && op_valid) begin
          checks++;
          if (got !== held) begin
            fails++;
            $display("FAIL R10 stalled output changed: got %h exp %h", got, held);
          end
        end
        if (op_valid && !op_ready) begin
          checks++;
          if (iss_ready !== 1'b0) begin
            fails++;
            $display("FAIL R10 iss_ready while stalled: got %b exp 0", iss_ready);
          end
        end
        was_stalled = op_valid && !op_ready;
        held = got;
        if (op_valid && op_ready) begin
          checks++;
          if (sb.size() == 0) begin
            fails++;
            $display("FAIL unexpected output: got %h exp none", got);
          end else begin
            item_t e;
            string r;
            e = sb.pop_front();
            r = sb_req.pop_front();
            if (got !== e) begin
              fails++;
              $display("FAIL %s: got %h exp %h", r, got, e);
            end
          end
        end
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // Watchdog: an expired run counts as a failed check.
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout exp completion");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) begin mdl_d[i] = '0; mdl_s[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    checks++;
    if (op_valid !== 1'b0 || iss_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 idle after reset: got valid=%b ready=%b exp 0/1", op_valid, iss_ready);
    end

    // R1 and R9: every entry reads zero; the signatures are carried through.
    for (int i = 0; i < 16; i++) begin
      set_issue(i, i + 16, i % 8, (i + 3) % 8, (i + 5) % 8);
      tick("R1");
    end

    // R5: fill entries through both buses.
    for (int i = 0; i < 8; i++) begin
      set_bus(0, 1'b1, i * 3 + 1, 32'hA000_0000 + i * 17, i);
      set_bus(1, 1'b1, i * 3 + 2, 32'h5000_1000 ^ (i << 8), 7 - i);
      tick("R5");
    end
    for (int i = 0; i < 8; i++) begin
      set_issue(i * 3 + 1, i * 3 + 2, i, 7 - i, 2);
      tick("R5");
    end

    // R2: buses busy on other tags, so both sources come from the array.
    set_issue(1, 2, 1, 2, 3);
    set_bus(0, 1'b1, 30, 32'hDEAD_0001, 5);
    set_bus(1, 1'b1, 31, 32'hDEAD_0002, 6);
    tick("R2");

    // R3 and R8: each source matches a different bus.
    set_issue(4, 5, 3, 4, 5);
    set_bus(0, 1'b1, 5, 32'h1111_0005, 1);
    set_bus(1, 1'b1, 4, 32'h2222_0004, 6);
    tick("R3");
    // R8: source 1 from a bus, source 2 from the array.
    set_issue(7, 8, 6, 1, 0);
    set_bus(0, 1'b1, 7, 32'h3333_0007, 3);
    tick("R8");

    // R4: both buses hit the same source; bus 0 wins.
    set_issue(10, 10, 2, 2, 7);
    set_bus(0, 1'b1, 10, 32'h4444_000A, 5);
    set_bus(1, 1'b1, 10, 32'h9999_000A, 2);
    tick("R4");
    // R6: the array kept bus 0's values.
    set_issue(10, 11, 0, 1, 2);
    tick("R6");

    // R7: same-cycle write and read, then a later read from the array.
    set_issue(12, 12, 4, 4, 4);
    set_bus(1, 1'b1, 12, 32'h7777_000C, 3);
    tick("R7");
    set_issue(12, 0, 5, 0, 1);
    tick("R7");

    // R11: a matching tag without valid neither bypasses nor writes.
    set_issue(13, 13, 1, 1, 1);
    set_bus(0, 1'b0, 13, 32'hBAD0_000D, 7);
    set_bus(1, 1'b0, 13, 32'hBAD1_000D, 6);
    tick("R11");
    set_issue(13, 1, 2, 3, 4);
    tick("R11");

    // R10: stall the output and offer a second instruction.
    st_ordy = 1'b0;
    set_issue(1, 2, 7, 6, 5);
    tick("R10");
    for (int k = 0; k < 3; k++) begin
      set_issue(4, 5, 1, 2, 3);
      tick("R10");
      checks++;
      if (accepted) begin
        fails++;
        $display("FAIL R10 accepted while stalled: got 1 exp 0");
      end
    end
    st_ordy = 1'b1;
    set_issue(4, 5, 1, 2, 3);
    tick("R10");

    // Drain the scoreboard.
    for (int k = 0; k < 50 && sb.size() != 0; k++) tick("drain");
    tick("drain");
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R9 items never delivered: got %0d left exp 0", sb.size());
    end
    done = 1'b1;
    summary();
  end
endmodule